// File: doc/BRIEF.md
# Sub-second real-time counter with alarms

This block keeps time in a slow clock domain (nominally 32.768 kHz). A 15-bit fraction counter advances once per slow-clock cycle. When it wraps from its top value back to zero, it advances a 32-bit seconds counter on that same slow edge. Each counter has its own alarm value and its own mode bit. In match mode the alarm fires when the counter steps onto the alarm value. In step mode the alarm fires on every advance of that counter. A fired alarm sets a sticky flag. The single level interrupt output is the OR of each flag gated by that flag's enable bit.

Software works through a simple write and read port in a fast bus clock domain. An accepted write is held in a holding register. A toggle then carries it into the slow domain over a two-flop synchronizer, and the toggle comes back as an acknowledge. Two busy flags remain set until that acknowledge returns. While a write is pending, further writes are dropped, so software polls the busy flags between writes.

Counter and flag reads are served from a snapshot. The slow domain captures the snapshot on one of its edges and passes it to the bus domain under a handshake. The fraction and seconds values read together therefore always come from the same slow cycle.

Top module: `rtc_subsec_timer`

## Requirements
- R1: After both resets, the fraction counter, the seconds counter, both flags, both busy flags and the interrupt read zero.
- R2: While control bit 0 (fraction run) is set, the fraction counter advances by one per slow cycle and wraps from 0x7FFF to 0. While the bit is clear, the counter holds its value.
- R3: On the slow edge where the fraction counter wraps, the seconds counter advances by one, provided control bit 1 (seconds run) is set. A (fraction, seconds) pair read at read addresses 0 and 1 never shows a wrapped fraction with stale seconds.
- R4: A write to address 1 loads the fraction counter and a write to address 2 loads the seconds counter.
- R5: Address 3 holds the fraction alarm and address 4 holds the seconds alarm. In match mode (mode bit 0), a flag is set only when its counter advances onto the alarm value, and a counter that never reaches that value sets no flag.
- R6: In step mode (control bit 4 for the fraction counter, bit 5 for the seconds counter), every advance of that counter sets its flag, whatever the alarm value.
- R7: The interrupt is high when the fraction flag is set with control bit 2 set, or when the seconds flag is set with control bit 3 set. A flag still sets while its enable bit is clear.
- R8: A write to address 5 clears the fraction flag if data bit 0 is 1 and clears the seconds flag if data bit 1 is 1. A flag whose data bit is 0 is left unchanged.
- R9: A control write (address 0) with data bit 6 set clears both counters and both flags. Bits 5:0 of the same write are stored as the new control value.
- R10: Status (read address 2) gives the fraction flag in bit 0, the seconds flag in bit 1, control-write busy in bit 2 and any-write busy in bit 3. Bit 3 is set from the cycle after a write is accepted until the acknowledge returns. Bit 2 is set over the same interval, but only for writes to address 0.
- R11: A write presented while bit 3 of status is set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| slow_clk | input | 1 | Slow timekeeping clock |
| slow_rst_n | input | 1 | Synchronous active-low reset, slow domain |
| wr_valid | input | 1 | Write strobe, one bus cycle per write |
| wr_addr | input | 3 | Write register select (0 control … 5 flag clear) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read select: 0 fraction, 1 seconds, 2 status |
| rd_data | output | 32 | Read data, combinational from bus-domain state |
| irq | output | 1 | Level interrupt, slow domain |

## Verification
Any-write busy rises one bus edge after a write is accepted, so the bench reads status at the falling edge that follows the write. The write takes effect on the third slow edge after acceptance, and busy clears two bus edges after that. The bench therefore polls busy, with a bound, before any dependent step. A snapshot reaches the read port a few slow cycles after the slow edge it was taken on, so stopped counters are read only after a settle time of about twelve slow cycles. Alarm and interrupt results are checked inside bounded wait windows, and exact slow-edge timing is left to the in-RTL properties. The wrap test reads both counters in one instant on every bus cycle and counts pairs that are not coherent.

// File: rtl/rtc_pkg.sv
// Shared encodings for the sub-second real-time counter.
// Assumes: write data is at least as wide as the seconds counter.
package rtc_pkg;
    localparam int DATA_W         = 32;
    localparam int DEF_SUB_W      = 15;
    localparam int DEF_SEC_W      = 32;
    localparam int CTRL_BITS      = 6;
    localparam int CTRL_RESET_BIT = 6;

    typedef enum logic [2:0] {
        WA_CTRL      = 3'd0,
        WA_SUB_LOAD  = 3'd1,
        WA_SEC_LOAD  = 3'd2,
        WA_SUB_ALARM = 3'd3,
        WA_SEC_ALARM = 3'd4,
        WA_FLAG_CLR  = 3'd5
    } waddr_e;

    typedef enum logic [1:0] {
        RA_SUB    = 2'd0,
        RA_SEC    = 2'd1,
        RA_STATUS = 2'd2
    } raddr_e;

    // Control register layout, bit 0 (sub_run) last.
    typedef struct packed {
        logic sec_mode;
        logic sub_mode;
        logic sec_ie;
        logic sub_ie;
        logic sec_run;
        logic sub_run;
    } ctrl_t;
endpackage

// File: rtl/rtc_sync_bit.sv
// Multi-stage single-bit synchronizer into the clock domain of clk.
// Assumes: d is a slowly changing level (toggle protocol).
module rtc_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            // Single flop stage.
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '0;
                else        sr <= d;
            end
        end else begin : g_chain
            // Shift chain of STAGES flops.
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/rtc_slow_core.sv
// Slow-domain core: applies handed-over writes, runs the fraction and
// seconds counters, evaluates alarms, keeps flags, drives the interrupt
// and publishes a coherent snapshot under a toggle handshake.
// Assumes: hold_addr/hold_data are stable while req_tgl differs from ack_tgl.
module rtc_slow_core
    import rtc_pkg::*;
#(
    parameter int SUB_W = DEF_SUB_W,
    parameter int SEC_W = DEF_SEC_W
) (
    input  logic                     slow_clk,
    input  logic                     slow_rst_n,
    input  logic                     req_tgl,
    input  logic [2:0]               hold_addr,
    input  logic [DATA_W-1:0]        hold_data,
    output logic                     ack_tgl,
    input  logic                     snap_ack,
    output logic                     snap_tgl,
    output logic [SUB_W+SEC_W+1:0]   snap_data,
    output logic                     irq
);
    logic             req_s, apply, snap_ack_s;
    logic             wr_ctrl, wr_subld, wr_secld, wr_suba, wr_seca, wr_clr, clr_all;
    ctrl_t            ctrl_q;
    logic [SUB_W-1:0] sub_q, sub_alarm, sub_inc;
    logic [SEC_W-1:0] sec_q, sec_alarm, sec_inc;
    logic             sub_adv, sub_wrap, sec_adv, sub_evt, sec_evt;
    logic             sub_flag, sec_flag;
    logic [1:0]       flag_clr;

    rtc_sync_bit #(.STAGES(2)) u_req_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(req_tgl), .q(req_s));
    rtc_sync_bit #(.STAGES(2)) u_snap_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(snap_ack), .q(snap_ack_s));

    assign apply    = req_s ^ ack_tgl;
    assign wr_ctrl  = apply && (hold_addr == WA_CTRL);
    assign wr_subld = apply && (hold_addr == WA_SUB_LOAD);
    assign wr_secld = apply && (hold_addr == WA_SEC_LOAD);
    assign wr_suba  = apply && (hold_addr == WA_SUB_ALARM);
    assign wr_seca  = apply && (hold_addr == WA_SEC_ALARM);
    assign wr_clr   = apply && (hold_addr == WA_FLAG_CLR);
    assign clr_all  = wr_ctrl && hold_data[CTRL_RESET_BIT];
    assign flag_clr = wr_clr ? hold_data[1:0] : 2'b00;

    // Acknowledge: remember the last request toggle handled.
    always_ff @(posedge slow_clk) begin
        if (!slow_rst_n) ack_tgl <= 1'b0;
        else             ack_tgl <= req_s;
    end

    // Configuration registers written from the bus.
    always_ff @(posedge slow_clk) begin
        if (!slow_rst_n) begin
            ctrl_q    <= '0;
            sub_alarm <= '0;
            sec_alarm <= '0;
        end else begin
            if (wr_ctrl) ctrl_q    <= ctrl_t'(hold_data[CTRL_BITS-1:0]);
            if (wr_suba) sub_alarm <= hold_data[SUB_W-1:0];
            if (wr_seca) sec_alarm <= hold_data[SEC_W-1:0];
        end
    end

    assign sub_inc  = sub_q + 1'b1;
    assign sec_inc  = sec_q + 1'b1;
    assign sub_adv  = ctrl_q.sub_run && !clr_all && !wr_subld;
    assign sub_wrap = sub_adv && (sub_q == '1);
    assign sec_adv  = sub_wrap && ctrl_q.sec_run && !clr_all && !wr_secld;
    assign sub_evt  = sub_adv && (ctrl_q.sub_mode || (sub_inc == sub_alarm));
    assign sec_evt  = sec_adv && (ctrl_q.sec_mode || (sec_inc == sec_alarm));

    // Fraction and seconds counters, advanced together on a wrap.
    always_ff @(posedge slow_clk) begin
        if (!slow_rst_n || clr_all) begin
            sub_q <= '0;
            sec_q <= '0;
        end else begin
            if (wr_subld)     sub_q <= hold_data[SUB_W-1:0];
            else if (sub_adv) sub_q <= sub_inc;
            if (wr_secld)     sec_q <= hold_data[SEC_W-1:0];
            else if (sec_adv) sec_q <= sec_inc;
        end
    end

    // Sticky alarm flags; a new event wins over a same-edge clear.
    always_ff @(posedge slow_clk) begin
        if (!slow_rst_n || clr_all) begin
            sub_flag <= 1'b0;
            sec_flag <= 1'b0;
        end else begin
            sub_flag <= (sub_flag && !flag_clr[0]) || sub_evt;
            sec_flag <= (sec_flag && !flag_clr[1]) || sec_evt;
        end
    end

    assign irq = (sub_flag && ctrl_q.sub_ie) || (sec_flag && ctrl_q.sec_ie);

    // Snapshot publisher: capture whenever the bus side has taken the last one.
    always_ff @(posedge slow_clk) begin
        if (!slow_rst_n) begin
            snap_tgl  <= 1'b0;
            snap_data <= '0;
        end else if (snap_ack_s == snap_tgl) begin
            snap_data <= {sec_flag, sub_flag, sec_q, sub_q};
            snap_tgl  <= ~snap_tgl;
        end
    end

    // R3: a fraction wrap moves seconds on the very same edge.
    p_wrap_coherent_r3: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        (ctrl_q.sub_run && ctrl_q.sec_run && (sub_q == '1) && !apply)
        |=> ((sub_q == '0) && (sec_q == $past(sec_q) + 1'b1)));

    // R3: seconds never move without a wrap or a write.
    p_sec_hold_r3: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        (!(ctrl_q.sub_run && ctrl_q.sec_run && (sub_q == '1)) && !apply)
        |=> $stable(sec_q));

    // R2: a stopped fraction counter holds.
    p_sub_stop_r2: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        (!ctrl_q.sub_run && !apply) |=> $stable(sub_q));

    // R5: stepping onto the alarm value in match mode sets the flag.
    p_match_flag_r5: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        (ctrl_q.sub_run && !ctrl_q.sub_mode && (sub_inc == sub_alarm) && !apply)
        |=> sub_flag);
endmodule

// File: rtl/rtc_bus_side.sv
// Bus-domain side: accepts writes into a holding register, toggles a
// request into the slow domain, derives busy flags from the returned
// acknowledge, and keeps the latest slow-domain snapshot for reads.
// Assumes: one write per wr_valid cycle; writes while busy are dropped.
module rtc_bus_side
    import rtc_pkg::*;
#(
    parameter int SUB_W = DEF_SUB_W,
    parameter int SEC_W = DEF_SEC_W
) (
    input  logic                     bus_clk,
    input  logic                     bus_rst_n,
    input  logic                     wr_valid,
    input  logic [2:0]               wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [1:0]               rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     req_tgl,
    output logic [2:0]               hold_addr,
    output logic [DATA_W-1:0]        hold_data,
    input  logic                     ack_tgl,
    input  logic                     snap_tgl,
    input  logic [SUB_W+SEC_W+1:0]   snap_data,
    output logic                     snap_ack
);
    localparam int FLAG_LO = SUB_W + SEC_W;

    logic                   ack_b, snap_b, busy, ctrl_busy, accept;
    logic [SUB_W+SEC_W+1:0] rd_snap;

    rtc_sync_bit #(.STAGES(2)) u_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_b));
    rtc_sync_bit #(.STAGES(2)) u_snap_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(snap_tgl), .q(snap_b));

    assign busy      = req_tgl ^ ack_b;
    assign ctrl_busy = busy && (hold_addr == WA_CTRL);
    assign accept    = wr_valid && !busy;

    // Capture an accepted write and flip the request toggle.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            req_tgl   <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
        end else if (accept) begin
            req_tgl   <= ~req_tgl;
            hold_addr <= wr_addr;
            hold_data <= wr_data;
        end
    end

    // Take a new snapshot when its toggle arrives, then acknowledge it.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            snap_ack <= 1'b0;
            rd_snap  <= '0;
        end else if (snap_b != snap_ack) begin
            rd_snap  <= snap_data;
            snap_ack <= snap_b;
        end
    end

    // Read multiplexer over snapshot and live busy flags.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_SUB:    rd_data[SUB_W-1:0] = rd_snap[SUB_W-1:0];
            RA_SEC:    rd_data[SEC_W-1:0] = rd_snap[SUB_W +: SEC_W];
            RA_STATUS: rd_data[3:0] = {busy, ctrl_busy, rd_snap[FLAG_LO+1], rd_snap[FLAG_LO]};
            default:   rd_data = '0;
        endcase
    end

    // R10: an accepted write shows busy on the next cycle.
    p_busy_after_accept_r10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr_valid && !busy) |=> busy);

    // R11: the holding register is untouched while a write is pending.
    p_hold_stable_r11: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        busy |=> ($stable(hold_data) && $stable(hold_addr)));
endmodule

// File: rtl/rtc_subsec_timer.sv
// Top: sub-second real-time counter with alarms, split into a bus-domain
// front end and a slow-domain timekeeping core.
// Assumes: the two clocks are unrelated; each reset is synchronous to its clock.
module rtc_subsec_timer
    import rtc_pkg::*;
#(
    parameter int SUB_W = DEF_SUB_W,
    parameter int SEC_W = DEF_SEC_W
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    input  logic              wr_valid,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic                   req_tgl, ack_tgl, snap_tgl, snap_ack;
    logic [2:0]             hold_addr;
    logic [DATA_W-1:0]      hold_data;
    logic [SUB_W+SEC_W+1:0] snap_data;

    rtc_bus_side #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_bus (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .req_tgl(req_tgl), .hold_addr(hold_addr), .hold_data(hold_data),
        .ack_tgl(ack_tgl), .snap_tgl(snap_tgl), .snap_data(snap_data),
        .snap_ack(snap_ack));

    rtc_slow_core #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_core (
        .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .req_tgl(req_tgl), .hold_addr(hold_addr), .hold_data(hold_data),
        .ack_tgl(ack_tgl), .snap_ack(snap_ack), .snap_tgl(snap_tgl),
        .snap_data(snap_data), .irq(irq));
endmodule

// File: tb/rtc_subsec_timer_tb.sv
module rtc_subsec_timer_tb;
    logic        bus_clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        slow_rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;
    int          errors = 0;
    int          checks = 0;
    bit          done = 0;

    rtc_subsec_timer u_dut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .slow_clk(slow_clk),
        .slow_rst_n(slow_rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

    always #4 bus_clk = ~bus_clk;     // 125 MHz
    always #64 slow_clk = ~slow_clk;  // 16 bus cycles per slow cycle

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge bus_clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(2'd2, s);
            if (s[3:2] == 2'b00) return;
            @(negedge bus_clk);
        end
        chk("R10 busy timeout", s[3:2], 2'b00);
    endtask

    task automatic wr_idle(input logic [2:0] a, input logic [31:0] d);
        bus_write(a, d); wait_idle();
    endtask

    task automatic settle();
        repeat (200) @(negedge bus_clk);
    endtask

    task automatic wait_irq(input int cyc, output bit seen);
        seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge bus_clk);
            if (irq) begin seen = 1; return; end
        end
    endtask

    task automatic quiesce();
        wr_idle(3'd0, 32'h0); wr_idle(3'd5, 32'h3);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        settle();
        rd(2'd0, v); chk("R1 fraction", v, 0);
        rd(2'd1, v); chk("R1 seconds", v, 0);
        rd(2'd2, v); chk("R1 status", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_load_busy();
        logic [31:0] v;
        bus_write(3'd1, 32'h100);
        rd(2'd2, v); chk("R10 any busy on load", v[3:2], 2'b10);
        wait_idle();
        bus_write(3'd0, 32'h0);
        rd(2'd2, v); chk("R10 ctrl busy", v[3:2], 2'b11);
        wait_idle();
        rd(2'd2, v); chk("R10 busy cleared", v[3:2], 2'b00);
        wr_idle(3'd2, 32'd7);
        settle();
        rd(2'd0, v); chk("R4 fraction load", v, 32'h100);
        rd(2'd1, v); chk("R4 seconds load", v, 32'd7);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        bus_write(3'd1, 32'h200);
        bus_write(3'd1, 32'h300);
        wait_idle(); settle();
        rd(2'd0, v); chk("R11 write while busy dropped", v, 32'h200);
    endtask

    task automatic t_run_stop();
        logic [31:0] v, w;
        wr_idle(3'd1, 32'h10);
        bus_write(3'd0, 32'h1);
        repeat (20) @(posedge slow_clk);
        bus_write(3'd0, 32'h0);
        wait_idle(); settle();
        rd(2'd0, v);
        chk("R2 run count in range", {31'd0, (v >= 32'h1E && v <= 32'h2A)}, 1);
        settle();
        rd(2'd0, w); chk("R2 stopped holds", w, v);
    endtask

    task automatic t_wrap();
        logic [31:0] s, c;
        int bad = 0;
        wr_idle(3'd1, 32'h7FF0); wr_idle(3'd2, 32'd41); settle();
        bus_write(3'd0, 32'h3);
        for (int i = 0; i < 600; i++) begin
            @(negedge bus_clk);
            rd(2'd0, s); rd(2'd1, c);
            if (!((c == 41 && s >= 32'h7FF0) || (c == 42 && s < 32'h100))) bad++;
        end
        chk("R3 incoherent pairs", bad, 0);
        chk("R3 seconds advanced", c, 32'd42);
        chk("R2 fraction wrapped", {31'd0, s < 32'h40}, 1);
        quiesce();
    endtask

    task automatic t_sub_match();
        logic [31:0] v; bit seen;
        quiesce();
        wr_idle(3'd1, 32'h20); wr_idle(3'd3, 32'h28);
        bus_write(3'd0, 32'h5);
        chk("R7 irq low before match", {31'd0, irq}, 0);
        wait_irq(1600, seen);
        chk("R5 fraction match irq", {31'd0, seen}, 1);
        wr_idle(3'd0, 32'h4); settle();
        rd(2'd2, v); chk("R5 flags after match", v[1:0], 2'b01);
        rd(2'd0, v); chk("R5 match not early", {31'd0, (v >= 32'h28 && v < 32'h40)}, 1);
        // flag clear
        wr_idle(3'd5, 32'h2); settle();
        chk("R8 other flag kept irq", {31'd0, irq}, 1);
        wr_idle(3'd5, 32'h1); settle();
        chk("R8 cleared irq", {31'd0, irq}, 0);
        rd(2'd2, v); chk("R8 flags cleared", v[1:0], 2'b00);
    endtask

    task automatic t_no_match();
        bit seen;
        quiesce();
        wr_idle(3'd1, 32'h30); wr_idle(3'd3, 32'h10);
        bus_write(3'd0, 32'h5);
        wait_irq(600, seen);
        chk("R5 no match no irq", {31'd0, seen}, 0);
        quiesce();
    endtask

    task automatic t_gate();
        logic [31:0] v; bit seen;
        wr_idle(3'd1, 32'h40); wr_idle(3'd3, 32'h42);
        bus_write(3'd0, 32'h1);
        wait_irq(600, seen);
        chk("R7 disabled irq stays low", {31'd0, seen}, 0);
        wr_idle(3'd0, 32'h0); settle();
        rd(2'd2, v); chk("R7 flag set while disabled", v[1:0], 2'b01);
        wr_idle(3'd0, 32'h4);
        chk("R7 enable raises irq", {31'd0, irq}, 1);
        quiesce();
    endtask

    task automatic t_step_modes();
        logic [31:0] v; bit seen;
        wr_idle(3'd1, 32'h50); wr_idle(3'd3, 32'h10);
        bus_write(3'd0, 32'h15);
        wait_irq(400, seen);
        chk("R6 fraction step irq", {31'd0, seen}, 1);
        quiesce();
        wr_idle(3'd2, 32'd100); wr_idle(3'd4, 32'd0); wr_idle(3'd1, 32'h7FF8);
        bus_write(3'd0, 32'h2B);
        wait_irq(1600, seen);
        chk("R6 seconds step irq", {31'd0, seen}, 1);
        wr_idle(3'd0, 32'h8); settle();
        rd(2'd2, v); chk("R6 seconds flag only", v[1:0], 2'b10);
        rd(2'd1, v); chk("R3 seconds after wrap", v, 32'd101);
        quiesce();
    endtask

    task automatic t_sec_match_and_reset();
        logic [31:0] v; bit seen;
        wr_idle(3'd2, 32'd9); wr_idle(3'd4, 32'd10); wr_idle(3'd1, 32'h7FF8);
        bus_write(3'd0, 32'h0B);
        wait_irq(1600, seen);
        chk("R5 seconds match irq", {31'd0, seen}, 1);
        wr_idle(3'd0, 32'h8); settle();
        rd(2'd1, v); chk("R5 seconds at alarm", v, 32'd10);
        wr_idle(3'd0, 32'h40); settle();
        rd(2'd0, v); chk("R9 fraction cleared", v, 0);
        rd(2'd1, v); chk("R9 seconds cleared", v, 0);
        rd(2'd2, v); chk("R9 flags cleared", v[1:0], 0);
        chk("R9 irq low", {31'd0, irq}, 0);
    endtask

    initial begin
        repeat (40) @(negedge bus_clk);
        bus_rst_n = 1'b1; slow_rst_n = 1'b1;
        t_reset();
        t_load_busy();
        t_ignored();
        t_run_stop();
        t_wrap();
        t_sub_match();
        t_no_match();
        t_gate();
        t_step_modes();
        t_sec_match_and_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge bus_clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule